// File: doc/BRIEF.md
# Short-Vector Register Address Sequencer

This block turns one floating-point short-vector operation into an ordered stream of register-file indices. A start pulse supplies the precision, the programmed length, a stride code and three starting register numbers: destination, first source and second source. The block then issues one index triple per cycle under a valid strobe. An execution unit consumes the triples in the order they arrive. A two-operand mode issues only the destination and the second source.

The register file is split into banks of 8 single-precision or 4 double-precision registers. Advancing an index by the stride wraps around inside its own bank and never moves into a neighbouring bank. Some banks are scalar banks. A destination in a scalar bank shortens the operation to one element. A second source in a scalar bank is held fixed while the other indices advance. Settings that have no defined result raise an unpredictable flag, and no elements are issued.

Top module: `svec_addr_seq`

## Requirements
- R1: The bank size is 8 when `dbl_i`=0 and 4 when `dbl_i`=1. Each advance replaces an index x with (x - x mod B) + ((x mod B + stride) mod B), so every index stays in its starting bank.
- R2: `stride_i` code 2'b01 means a stride of 1 and 2'b10 means a stride of 2. Codes 2'b00 and 2'b11 raise `unpred_o` and issue no elements.
- R3: If stride times length is greater than the bank size, `unpred_o` is raised and no elements are issued.
- R4: Length is `len_i`+1, giving 1 to 8. A length of 1 with a stride of 2 is unpredictable. A length of 1 with a stride of 1 issues exactly one element carrying the given register numbers.
- R5: Scalar banks are single registers 0-7 and double registers 0-3 and 16-19. If the destination lies in a scalar bank, exactly one element is issued whatever the programmed length.
- R6: If the second source lies in a scalar bank, `srcb_o` keeps the same value on every element while the destination and first source advance. Otherwise all three indices advance.
- R7: With `two_op_i`=1, `srca_o` reads 0 on every element.
- R8: The first element appears in the cycle after the clock edge that accepts start. Later elements follow on consecutive cycles. `done_o` pulses for one cycle, one cycle after the last element. On an unpredictable operation, `unpred_o` and `done_o` pulse together in the cycle after acceptance.
- R9: Start is ignored while elements are being issued. The running operation continues unchanged.
- R10: After reset, and in any cycle without a valid element, every output reads 0, except `done_o` and `unpred_o` during their pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| dbl_i | input | 1 | 1 selects double precision |
| two_op_i | input | 1 | 1 selects two-operand mode |
| len_i | input | 3 | Length minus one |
| stride_i | input | 2 | Stride code |
| dst_i | input | 5 | Starting destination index |
| srca_i | input | 5 | Starting first-source index |
| srcb_i | input | 5 | Starting second-source index |
| elem_vld_o | output | 1 | Element triple valid |
| dst_o | output | 5 | Destination index |
| srca_o | output | 5 | First-source index |
| srcb_o | output | 5 | Second-source index |
| done_o | output | 1 | Operation finished (one-cycle pulse) |
| unpred_o | output | 1 | Operation unpredictable (one-cycle pulse) |
| busy_o | output | 1 | Elements being issued |

## Verification
Each index of an element is computed from the index before it. A wrong step or wrap therefore shows up at the ports on the first element that crosses a bank edge, and every later element is wrong as well. A wrong remaining-count shows up as a `done_o` pulse that arrives one or more cycles early or late, or as extra or missing valid cycles. A wrong scalar-bank decode shows up on the second element: a held second source moves, or a scalar destination issues a second element. The reference model compares every output on every cycle, so each of these faults is caught in the cycle where it first appears.

// File: rtl/svseq_pkg.sv
package svseq_pkg;
  localparam int IDX_W   = 5;
  localparam int LEN_W   = 3;
  localparam int STR_W   = 2;
  localparam int SP_BANK = 8;
  localparam int DP_BANK = 4;

  // Circular advance inside the bank that holds idx
  function automatic logic [IDX_W-1:0] bank_next(input logic [IDX_W-1:0] idx,
                                                 input logic dbl,
                                                 input logic [STR_W-1:0] amt);
    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] sum;
    mask = dbl ? IDX_W'(DP_BANK - 1) : IDX_W'(SP_BANK - 1);
    sum  = idx + IDX_W'(amt);
    return (idx & ~mask) | (sum & mask);
  endfunction

  // Scalar-bank membership
  function automatic logic in_scalar_bank(input logic [IDX_W-1:0] idx,
                                          input logic dbl);
    if (dbl) return (idx < IDX_W'(DP_BANK)) ||
                    (idx >= IDX_W'(16) && idx < IDX_W'(16 + DP_BANK));
    return idx < IDX_W'(SP_BANK);
  endfunction
endpackage

// File: rtl/svseq_check.sv
module svseq_check
  import svseq_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int LW = LEN_W
) (
  input  logic          dbl_i,
  input  logic [LW-1:0] len_m1_i,
  input  logic [1:0]    code_i,
  input  logic [IW-1:0] dst_i,
  input  logic [IW-1:0] srcb_i,
  output logic          bad_o,
  output logic [1:0]    amt_o,
  output logic [LW-1:0] eff_m1_o,
  output logic          sb_scal_o
);
  localparam int PW = LW + 3;
  logic [PW-1:0] prod;
  logic [PW-1:0] bank;
  logic          dst_scal;

  always_comb begin
    case (code_i)
      2'b01:   amt_o = 2'd1;
      2'b10:   amt_o = 2'd2;
      default: amt_o = 2'd0;
    endcase
    prod      = PW'(amt_o) * (PW'(len_m1_i) + PW'(1));
    bank      = dbl_i ? PW'(DP_BANK) : PW'(SP_BANK);
    bad_o     = (amt_o == 2'd0) || (prod > bank) ||
                ((len_m1_i == '0) && (amt_o != 2'd1));
    dst_scal  = in_scalar_bank(dst_i, dbl_i);
    sb_scal_o = in_scalar_bank(srcb_i, dbl_i);
    eff_m1_o  = dst_scal ? '0 : len_m1_i;
  end
endmodule

// File: rtl/svseq_step.sv
module svseq_step
  import svseq_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic [IW-1:0] idx_i,
  input  logic          dbl_i,
  input  logic [1:0]    amt_i,
  output logic [IW-1:0] nxt_o
);
  always_comb nxt_o = bank_next(idx_i, dbl_i, amt_i);
endmodule

// File: rtl/svec_addr_seq.sv
module svec_addr_seq
  import svseq_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int LW = LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          dbl_i,
  input  logic          two_op_i,
  input  logic [LW-1:0] len_i,
  input  logic [1:0]    stride_i,
  input  logic [IW-1:0] dst_i,
  input  logic [IW-1:0] srca_i,
  input  logic [IW-1:0] srcb_i,
  output logic          elem_vld_o,
  output logic [IW-1:0] dst_o,
  output logic [IW-1:0] srca_o,
  output logic [IW-1:0] srcb_o,
  output logic          done_o,
  output logic          unpred_o,
  output logic          busy_o
);
  localparam int LANES = 3;

  logic          act_q, dbl_q, two_q, sbfix_q, done_q, unp_q;
  logic [1:0]    amt_q;
  logic [LW-1:0] rem_q;
  logic [IW-1:0] idx_q [LANES];
  logic [IW-1:0] nxt_w [LANES];

  logic          bad_w, sb_scal_w;
  logic [1:0]    amt_w;
  logic [LW-1:0] eff_m1_w;

  // Named internal events
  logic          accept_w, last_w, dst_scal_w;
  logic [IW-1:0] bank_mask_w;

  svseq_check #(.IW(IW), .LW(LW)) u_check (
    .dbl_i(dbl_i), .len_m1_i(len_i), .code_i(stride_i),
    .dst_i(dst_i), .srcb_i(srcb_i),
    .bad_o(bad_w), .amt_o(amt_w), .eff_m1_o(eff_m1_w), .sb_scal_o(sb_scal_w)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    svseq_step #(.IW(IW)) u_step (
      .idx_i(idx_q[g]), .dbl_i(dbl_q), .amt_i(amt_q), .nxt_o(nxt_w[g])
    );
  end

  assign accept_w    = start_i && !act_q;
  assign last_w      = act_q && (rem_q == '0);
  assign dst_scal_w  = in_scalar_bank(idx_q[0], dbl_q);
  assign bank_mask_w = dbl_q ? IW'(DP_BANK - 1) : IW'(SP_BANK - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      dbl_q   <= 1'b0;
      two_q   <= 1'b0;
      sbfix_q <= 1'b0;
      done_q  <= 1'b0;
      unp_q   <= 1'b0;
      amt_q   <= '0;
      rem_q   <= '0;
      for (int i = 0; i < LANES; i++) idx_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      unp_q  <= 1'b0;
      if (accept_w) begin
        if (bad_w) begin
          unp_q  <= 1'b1;
          done_q <= 1'b1;
        end else begin
          act_q    <= 1'b1;
          dbl_q    <= dbl_i;
          two_q    <= two_op_i;
          sbfix_q  <= sb_scal_w;
          amt_q    <= amt_w;
          rem_q    <= eff_m1_w;
          idx_q[0] <= dst_i;
          idx_q[1] <= two_op_i ? '0 : srca_i;
          idx_q[2] <= srcb_i;
        end
      end else if (last_w) begin
        act_q  <= 1'b0;
        done_q <= 1'b1;
      end else if (act_q) begin
        rem_q    <= rem_q - LW'(1);
        idx_q[0] <= nxt_w[0];
        idx_q[1] <= two_q ? '0 : nxt_w[1];
        idx_q[2] <= sbfix_q ? idx_q[2] : nxt_w[2];
      end
    end
  end

  assign elem_vld_o = act_q;
  assign busy_o     = act_q;
  assign dst_o      = act_q ? idx_q[0] : '0;
  assign srca_o     = act_q ? idx_q[1] : '0;
  assign srcb_o     = act_q ? idx_q[2] : '0;
  assign done_o     = done_q;
  assign unpred_o   = unp_q;

  // R8
  unpred_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unpred_o |-> done_o);
  // R8
  vld_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(elem_vld_o && done_o));
  // R2
  unpred_no_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unpred_o |-> !elem_vld_o);
  // R1
  same_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_vld_o && $past(elem_vld_o)) |->
      ((dst_o & ~bank_mask_w) == ($past(dst_o) & ~bank_mask_w)));
  // R6
  srcb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_vld_o && sbfix_q) |=> (!elem_vld_o || $stable(srcb_o)));
  // R7
  two_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_vld_o && two_q) |-> (srca_o == '0));
  // R5
  scalar_dst_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_vld_o && dst_scal_w) |=> !elem_vld_o);
  // R9
  run_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !last_w) |=> elem_vld_o);
endmodule

// File: tb/sim_svec_addr_seq.sv
module sim_svec_addr_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, dbl_i = 1'b0, two_op_i = 1'b0;
  logic [2:0] len_i = '0;
  logic [1:0] stride_i = '0;
  logic [4:0] dst_i = '0, srca_i = '0, srcb_i = '0;
  logic       elem_vld_o, done_o, unpred_o, busy_o;
  logic [4:0] dst_o, srca_o, srcb_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // expected word: {vld, done, unpred, busy, dst, srca, srcb}
  logic [18:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  svec_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dbl_i(dbl_i),
    .two_op_i(two_op_i), .len_i(len_i), .stride_i(stride_i),
    .dst_i(dst_i), .srca_i(srca_i), .srcb_i(srcb_i),
    .elem_vld_o(elem_vld_o), .dst_o(dst_o), .srca_o(srca_o),
    .srcb_o(srcb_o), .done_o(done_o), .unpred_o(unpred_o), .busy_o(busy_o)
  );

  function automatic int mdl_step(int x, int bsz, int st);
    return (x - (x % bsz)) + (((x % bsz) + st) % bsz);
  endfunction

  function automatic bit mdl_scalar(int x, bit dbl);
    if (dbl) return (x <= 3) || (x >= 16 && x <= 19);
    return x <= 7;
  endfunction

  task automatic push(bit v, bit dn, bit up, int d, int a, int b, string t);
    exp_q.push_back({v, dn, up, v, 5'(d), 5'(a), 5'(b)});
    tag_q.push_back(t);
  endtask

  task automatic compare();
    logic [18:0] e;
    logic [18:0] got;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
    end else begin
      e = '0;
      t = "R10";
    end
    got = {elem_vld_o, done_o, unpred_o, busy_o, dst_o, srca_o, srcb_o};
    checks++;
    if (got !== e) begin
      fails++;
      $display("FAIL %s: got vld/done/unp/busy=%b%b%b%b d=%0d a=%0d b=%0d expected %b%b%b%b d=%0d a=%0d b=%0d",
               t, got[18], got[17], got[16], got[15], got[14:10], got[9:5], got[4:0],
               e[18], e[17], e[16], e[15], e[14:10], e[9:5], e[4:0]);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    start_i = 1'b0;
  endtask

  task automatic issue(bit dbl, bit two, int len, logic [1:0] code,
                       int d, int a, int b, string t);
    int bsz, st, n;
    bit bad;
    dbl_i = dbl; two_op_i = two; len_i = 3'(len - 1); stride_i = code;
    dst_i = 5'(d); srca_i = 5'(a); srcb_i = 5'(b); start_i = 1'b1;
    bsz = dbl ? 4 : 8;
    st  = (code == 2'b01) ? 1 : (code == 2'b10) ? 2 : 0;
    bad = (st == 0) || (st * len > bsz) || (len == 1 && st != 1);
    if (bad) begin
      push(0, 1, 1, 0, 0, 0, t);
    end else begin
      n = mdl_scalar(d, dbl) ? 1 : len;
      for (int i = 0; i < n; i++) begin
        push(1, 0, 0, d, two ? 0 : a, b, t);
        d = mdl_step(d, bsz, st);
        a = mdl_step(a, bsz, st);
        if (!mdl_scalar(b, dbl)) b = mdl_step(b, bsz, st);
      end
      push(0, 1, 0, 0, 0, 0, t);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) tick();
  endtask

  initial begin
    // R10: reset and idle state
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (2) tick();
    // R1: single-precision vector run with stride 1
    issue(0, 0, 4, 2'b01, 8, 16, 24, "R1"); drain();
    // R1: stride 2 wrapping in the bank
    issue(0, 0, 4, 2'b10, 13, 22, 29, "R1"); drain();
    // R6: double precision, scalar second source is held
    issue(1, 0, 2, 2'b10, 5, 9, 2, "R6"); drain();
    // R6: double bank 20-23 wraps, second source 18 is scalar
    issue(1, 0, 4, 2'b01, 22, 27, 18, "R6"); drain();
    // R5: scalar destination in double bank 16-19
    issue(1, 0, 4, 2'b01, 17, 8, 12, "R5"); drain();
    // R5: scalar destination in single bank 0-7
    issue(0, 0, 8, 2'b01, 3, 12, 20, "R5"); drain();
    // R2: invalid stride codes
    issue(0, 0, 3, 2'b00, 8, 8, 8, "R2"); drain();
    issue(0, 0, 3, 2'b11, 8, 8, 8, "R2"); drain();
    // R3: stride times length over the bank size
    issue(1, 0, 3, 2'b10, 8, 12, 24, "R3"); drain();
    issue(0, 0, 5, 2'b10, 8, 12, 24, "R3"); drain();
    // R4: length 1
    issue(0, 0, 1, 2'b10, 9, 10, 11, "R4"); drain();
    issue(0, 0, 1, 2'b01, 9, 10, 11, "R4"); drain();
    // R7: two-operand mode, full-length run
    issue(0, 1, 8, 2'b01, 30, 14, 25, "R7"); drain();
    // R9: start while busy is ignored
    issue(0, 0, 8, 2'b01, 10, 18, 26, "R9");
    tick(); tick();
    dbl_i = 1'b1; len_i = 3'd0; stride_i = 2'b00; dst_i = 5'd1; start_i = 1'b1;
    drain();
    // R8: back-to-back operation, then idle
    issue(1, 0, 2, 2'b01, 29, 6, 7, "R8"); drain();
    repeat (3) tick();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule